// File: doc/BRIEF.md
# Branch Condition and Target Unit

This block resolves every control-transfer instruction of an 8-bit processor core. The decode stage hands it the opcode byte, the flag register, the loop counter register (B), HL, the program counter already advanced past the whole instruction, and the operand that the fetch stage read. The block decides whether the program counter is redirected, computes the next program counter, writes back a decremented loop counter when needed, and moves return addresses to and from an external stack one byte at a time.

An instruction is accepted when `op_valid` is high while `ready` is high. Instructions that touch no stack finish one cycle after acceptance. Calls, restarts and returns whose condition holds run a two-byte exchange with the stack over a request/acknowledge handshake before they finish. The stack memory, the stack pointer and instruction fetch are outside the block. The fetch stage always consumes the operand of a conditional jump or call, whatever the condition.

Top module: `brc_unit`

## Requirements
- R1: The condition index selects one test: 0 Z clear, 1 Z set, 2 C clear, 3 C set, 4 PV clear, 5 PV set, 6 S clear, 7 S set. The flag bits are S=bit 7, Z=bit 6, PV=bit 2 and C=bit 0, and the other flag bits have no effect. For jumps, calls and returns the index is opcode bits 5:3.
- R2: Opcode 0x18 always branches, and 0x20, 0x28, 0x30 and 0x38 branch only under conditions 0 to 3, with the index taken from opcode bits 4:3. The target is `pc_in` plus the sign-extended `operand[7:0]`.
- R3: Opcode 0x10 reports `b_wr` with `b_new` = `b_in` - 1 (mod 256) whether or not it branches. It branches to the relative target only when `b_new` is nonzero.
- R4: Opcode 0xC3 always jumps to `operand`. Opcodes 11ccc010 jump to `operand` only when condition ccc holds. When the condition fails, `next_pc` = `pc_in`.
- R5: Opcode 0xE9 sets `next_pc` to `hl_in` and causes no stack traffic.
- R6: Opcode 0xCD, and 11ccc100 when ccc holds, push `pc_in` high byte first and then low byte, then redirect to `operand`. A push byte moves on a cycle with `stk_push_req` and `stk_ack` both high, and a request is held with stable data until it is acknowledged. A call whose condition fails pushes nothing.
- R7: Opcodes 11ttt111 push `pc_in` in the same way as a call and redirect to ttt*8, with all other address bits zero.
- R8: Opcode 0xC9, and 11ccc000 when ccc holds, pop the low byte first and then the high byte, and set `next_pc` = {high, low}. A return whose condition fails pops nothing.
- R9: `done` is a one-cycle pulse, and for instructions without stack traffic it comes one cycle after acceptance. `redirect` is high together with `done` exactly when the branch is taken. `ready` is low while a stack exchange is in progress.
- R10: Any other opcode completes as not taken, with `next_pc` = `pc_in`, no `b_wr` and no stack traffic.
- R11: After reset `ready` = 1 and `done`, `redirect`, `b_wr`, `stk_push_req` and `stk_pop_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction offered this cycle |
| opcode | input | 8 | Unprefixed opcode byte |
| flags | input | 8 | Flag register |
| b_in | input | 8 | Current loop counter |
| pc_in | input | 16 | Program counter past the instruction |
| operand | input | 16 | Fetched operand (displacement in low byte) |
| hl_in | input | 16 | HL register pair |
| ready | output | 1 | Block can accept an instruction |
| done | output | 1 | Instruction resolved (one-cycle pulse) |
| redirect | output | 1 | Branch taken, with `done` |
| next_pc | output | 16 | Next program counter, valid with `done` |
| b_wr | output | 1 | Loop counter write-back strobe |
| b_new | output | 8 | Decremented loop counter |
| stk_push_req | output | 1 | Push byte request |
| stk_wdata | output | 8 | Byte to push |
| stk_pop_req | output | 1 | Pop byte request |
| stk_rdata | input | 8 | Popped byte, valid with `stk_ack` |
| stk_ack | input | 1 | Stack accepts or returns a byte |

## Verification
On every cycle the assertions check these rules: `redirect` appears only with `done`, push and pop requests never overlap, and `ready` is low while a request is pending. They also check that an unacknowledged push holds its data, that the high-byte push is followed by a second push, and that the loop counter write-back equals the accepted B minus one. Only the bench's sweeps can show the rest. These are the per-opcode condition decoding across all flag combinations, the arithmetic of the relative, absolute and restart targets, the byte order of the exchanged return address, and the absence of stack traffic for failed conditions and non-branch opcodes.

// File: rtl/brc_pkg.sv
// Shared types for the branch unit.
// Assumes unprefixed opcodes only; prefixed forms are decoded elsewhere.
package brc_pkg;
    typedef enum logic [3:0] {
        K_NONE, K_JP, K_JPCC, K_JR, K_JRCC, K_DJNZ,
        K_JPHL, K_CALL, K_CALLCC, K_RET, K_RETCC, K_RST
    } brc_kind_e;
endpackage

// File: rtl/brc_decode.sv
// Classifies an opcode byte into a transfer kind and extracts the condition
// index. Assumes the opcode is stable while being decoded; purely combinational.
module brc_decode
    import brc_pkg::*;
(
    input  logic [7:0] opcode,
    output brc_kind_e  kind,
    output logic [2:0] cc
);
    // Opcode classification; relative conditionals use only two index bits
    always_comb begin
        kind = K_NONE;
        cc   = opcode[5:3];
        casez (opcode)
            8'hC3:        kind = K_JP;
            8'h18:        kind = K_JR;
            8'h10:        kind = K_DJNZ;
            8'hE9:        kind = K_JPHL;
            8'hCD:        kind = K_CALL;
            8'hC9:        kind = K_RET;
            8'b001??000: begin
                kind = K_JRCC;
                cc   = {1'b0, opcode[4:3]};
            end
            8'b11???010:  kind = K_JPCC;
            8'b11???100:  kind = K_CALLCC;
            8'b11???000:  kind = K_RETCC;
            8'b11???111:  kind = K_RST;
            default:      kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/brc_cond.sv
// Evaluates one of eight flag conditions. Even indices test a flag clear,
// odd indices test it set. Assumes the flag layout S=7, Z=6, PV=2, C=0.
module brc_cond (
    input  logic [7:0] flags,
    input  logic [2:0] cc,
    output logic       hit
);
    logic       flag_sel;
    logic       unused_flag_bits;

    assign unused_flag_bits = ^{flags[5:3], flags[1]};

    // Pick the flag tested by the upper two index bits
    always_comb begin
        case (cc[2:1])
            2'd0:    flag_sel = flags[6];
            2'd1:    flag_sel = flags[0];
            2'd2:    flag_sel = flags[2];
            default: flag_sel = flags[7];
        endcase
    end

    // Low index bit chooses set versus clear
    assign hit = cc[0] ? flag_sel : ~flag_sel;
endmodule

// File: rtl/brc_target.sv
// Computes the branch destination for each kind. Assumes pc_in already
// points past the instruction. Returns pc_in for kinds without a target.
module brc_target
    import brc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  brc_kind_e         kind,
    input  logic [7:0]        opcode,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   operand,
    input  logic [PC_W-1:0]   hl_in,
    output logic [PC_W-1:0]   target
);
    localparam int EXT_W = PC_W - 8;
    localparam int RST_PAD = PC_W - 6;

    logic [PC_W-1:0] rel_tgt;
    logic [PC_W-1:0] rst_tgt;

    assign rel_tgt = pc_in + {{EXT_W{operand[7]}}, operand[7:0]};
    assign rst_tgt = {{RST_PAD{1'b0}}, opcode[5:3], 3'b000};

    // Destination select by kind
    always_comb begin
        case (kind)
            K_JP, K_JPCC, K_CALL, K_CALLCC: target = operand;
            K_JR, K_JRCC, K_DJNZ:           target = rel_tgt;
            K_JPHL:                         target = hl_in;
            K_RST:                          target = rst_tgt;
            default:                        target = pc_in;
        endcase
    end
endmodule

// File: rtl/brc_unit.sv
// Branch condition and target unit. Accepts one transfer instruction when
// ready, resolves it, and for taken calls, restarts and returns exchanges a
// two-byte return address with an external stack over req/ack.
// Assumes the stack handles its own pointer; bytes move when req && ack.
module brc_unit
    import brc_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [7:0]        opcode,
    input  logic [7:0]        flags,
    input  logic [7:0]        b_in,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   operand,
    input  logic [PC_W-1:0]   hl_in,
    output logic              ready,
    output logic              done,
    output logic              redirect,
    output logic [PC_W-1:0]   next_pc,
    output logic              b_wr,
    output logic [7:0]        b_new,
    output logic              stk_push_req,
    output logic [7:0]        stk_wdata,
    output logic              stk_pop_req,
    input  logic [7:0]        stk_rdata,
    input  logic              stk_ack
);
    localparam int HALF_W = PC_W / 2;

    typedef enum logic [2:0] {S_IDLE, S_PUSH_HI, S_PUSH_LO, S_POP_LO, S_POP_HI} st_e;

    st_e             state;
    brc_kind_e       kind;
    logic [2:0]      cc;
    logic            cond_hit;
    logic            taken;
    logic [7:0]      b_dec;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] ret_q;
    logic [PC_W-1:0] tgt_q;
    logic [7:0]      lo_q;
    logic            accept;
    logic            is_push;
    logic            is_pop;

    brc_decode u_dec (.opcode(opcode), .kind(kind), .cc(cc));
    brc_cond   u_cond (.flags(flags), .cc(cc), .hit(cond_hit));
    brc_target #(.PC_W(PC_W)) u_tgt (
        .kind(kind), .opcode(opcode), .pc_in(pc_in),
        .operand(operand), .hl_in(hl_in), .target(target)
    );

    assign b_dec  = b_in - 8'd1;
    assign accept = op_valid && (state == S_IDLE);

    // Taken decision per kind
    always_comb begin
        case (kind)
            K_JP, K_JR, K_JPHL, K_CALL, K_RET, K_RST: taken = 1'b1;
            K_JPCC, K_JRCC, K_CALLCC, K_RETCC:       taken = cond_hit;
            K_DJNZ:                                  taken = (b_dec != 8'd0);
            default:                                 taken = 1'b0;
        endcase
    end

    assign is_push = taken && (kind == K_CALL || kind == K_CALLCC || kind == K_RST);
    assign is_pop  = taken && (kind == K_RET || kind == K_RETCC);

    // Sequencer: resolves simple kinds at once, walks stack bytes otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            done     <= 1'b0;
            redirect <= 1'b0;
            b_wr     <= 1'b0;
            b_new    <= '0;
            next_pc  <= '0;
            ret_q    <= '0;
            tgt_q    <= '0;
            lo_q     <= '0;
        end else begin
            done     <= 1'b0;
            redirect <= 1'b0;
            b_wr     <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    if (is_push) begin
                        ret_q <= pc_in;
                        tgt_q <= target;
                        state <= S_PUSH_HI;
                    end else if (is_pop) begin
                        state <= S_POP_LO;
                    end else begin
                        done     <= 1'b1;
                        redirect <= taken;
                        next_pc  <= taken ? target : pc_in;
                        b_wr     <= (kind == K_DJNZ);
                        b_new    <= b_dec;
                    end
                end
                S_PUSH_HI: if (stk_ack) state <= S_PUSH_LO;
                S_PUSH_LO: if (stk_ack) begin
                    done     <= 1'b1;
                    redirect <= 1'b1;
                    next_pc  <= tgt_q;
                    state    <= S_IDLE;
                end
                S_POP_LO: if (stk_ack) begin
                    lo_q  <= stk_rdata;
                    state <= S_POP_HI;
                end
                S_POP_HI: if (stk_ack) begin
                    done     <= 1'b1;
                    redirect <= 1'b1;
                    next_pc  <= {stk_rdata, lo_q};
                    state    <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign ready        = (state == S_IDLE);
    assign stk_push_req = (state == S_PUSH_HI) || (state == S_PUSH_LO);
    assign stk_pop_req  = (state == S_POP_LO) || (state == S_POP_HI);
    assign stk_wdata    = (state == S_PUSH_HI) ? ret_q[PC_W-1:HALF_W] : ret_q[HALF_W-1:0];

    // R9: redirect never appears without done
    a_r9_redirect_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> done);

    // R6: push and pop never requested together
    a_r6_push_pop_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(stk_push_req && stk_pop_req));

    // R9: no new instruction accepted during a stack exchange
    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_push_req || stk_pop_req) |-> !ready);

    // R6: an unacknowledged push holds its request and data
    a_r6_push_held: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_push_req && !stk_ack) |=> (stk_push_req && $stable(stk_wdata)));

    // R6: after the high byte is accepted a second push follows
    a_r6_hi_then_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PUSH_HI && stk_ack) |=> (stk_push_req && stk_wdata == ret_q[HALF_W-1:0]));

    // R3: loop counter write-back is the accepted B minus one
    a_r3_djnz_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        b_wr |-> (b_new == $past(b_in) - 8'd1));
endmodule

// File: tb/tb_brc_unit.sv
module tb_brc_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [7:0]  opcode, flags, b_in;
    logic [15:0] pc_in, operand, hl_in;
    logic        ready, done, redirect, b_wr, stk_push_req, stk_pop_req, stk_ack;
    logic [15:0] next_pc;
    logic [7:0]  b_new, stk_wdata, stk_rdata;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    brc_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .flags(flags), .b_in(b_in), .pc_in(pc_in), .operand(operand),
        .hl_in(hl_in), .ready(ready), .done(done), .redirect(redirect),
        .next_pc(next_pc), .b_wr(b_wr), .b_new(b_new),
        .stk_push_req(stk_push_req), .stk_wdata(stk_wdata),
        .stk_pop_req(stk_pop_req), .stk_rdata(stk_rdata), .stk_ack(stk_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // R1 condition test from the requirement table
    function automatic bit cond_ok(input logic [2:0] idx, input logic [7:0] f);
        case (idx)
            3'd0: return !f[6];
            3'd1: return f[6];
            3'd2: return !f[0];
            3'd3: return f[0];
            3'd4: return !f[2];
            3'd5: return f[2];
            3'd6: return !f[7];
            default: return f[7];
        endcase
    endfunction

    // Reference outcome: act 0 none, 1 push, 2 pop
    task automatic model(input logic [7:0] op, f, b, input logic [15:0] pc, imm, hl,
                         output int act, output bit tk, output logic [15:0] tgt,
                         output bit bw, output logic [7:0] bn);
        logic [15:0] rel;
        rel = pc + {{8{imm[7]}}, imm[7:0]};
        act = 0; tk = 0; tgt = pc; bw = 0; bn = b - 8'd1;
        if (op == 8'h18) begin tk = 1; tgt = rel; end                        // R2
        else if (op inside {8'h20, 8'h28, 8'h30, 8'h38}) begin               // R2
            tk = cond_ok({1'b0, op[4:3]}, f); if (tk) tgt = rel;
        end else if (op == 8'h10) begin                                      // R3
            bw = 1; tk = (bn != 0); if (tk) tgt = rel;
        end else if (op == 8'hC3) begin tk = 1; tgt = imm; end               // R4
        else if (op[7:6] == 2'b11 && op[2:0] == 3'b010) begin                // R4
            tk = cond_ok(op[5:3], f); if (tk) tgt = imm;
        end else if (op == 8'hE9) begin tk = 1; tgt = hl; end                // R5
        else if (op == 8'hCD) begin tk = 1; tgt = imm; act = 1; end          // R6
        else if (op[7:6] == 2'b11 && op[2:0] == 3'b100) begin                // R6
            tk = cond_ok(op[5:3], f); if (tk) begin tgt = imm; act = 1; end
        end else if (op[7:6] == 2'b11 && op[2:0] == 3'b111) begin            // R7
            tk = 1; tgt = {10'd0, op[5:3], 3'd0}; act = 1;
        end else if (op == 8'hC9) begin tk = 1; act = 2; end                 // R8
        else if (op[7:6] == 2'b11 && op[2:0] == 3'b000) begin                // R8
            tk = cond_ok(op[5:3], f); if (tk) act = 2;
        end
    endtask

    task automatic run_op(input logic [7:0] op, f, b, input logic [15:0] pc, imm, hl,
                          input int dly, input logic [7:0] plo, phi);
        int act; bit tk; logic [15:0] tgt; bit bw; logic [7:0] bn;
        logic [7:0] pb [0:3];
        int pushes = 0, pops = 0, waitc = 0, cyc = 0;
        bit got = 0;
        model(op, f, b, pc, imm, hl, act, tk, tgt, bw, bn);
        if (act == 2) tgt = {phi, plo};
        @(negedge clk);
        op_valid = 1; opcode = op; flags = f; b_in = b; pc_in = pc; operand = imm; hl_in = hl;
        @(negedge clk);
        op_valid = 0; pc_in = 16'hDEAD; operand = 16'hBEEF; hl_in = 16'h0BAD; b_in = 8'h5C;
        while (!got && cyc < 60) begin
            if (done) got = 1;
            else begin
                stk_ack = 0;
                if (stk_push_req || stk_pop_req) begin
                    chk("R9 ready low while busy", 32'(ready), 0);
                    if (waitc >= dly) begin
                        stk_ack = 1; waitc = 0;
                        if (stk_push_req) begin
                            if (pushes < 4) pb[pushes] = stk_wdata;
                            pushes++;
                        end else begin
                            stk_rdata = (pops == 0) ? plo : phi;
                            pops++;
                        end
                    end else waitc++;
                end
                @(negedge clk);
                cyc++;
            end
        end
        stk_ack = 0;
        chk("R9 done seen", 32'(got), 1);
        if (act == 0) chk("R9 latency one cycle", 32'(cyc), 0);
        chk("R1/R2/R4 taken as redirect", 32'(redirect), 32'(tk));
        chk("R2/R4/R5/R7/R8/R10 next_pc", 32'(next_pc), 32'(tgt));
        chk("R3/R10 b_wr", 32'(b_wr), 32'(bw));
        if (bw) chk("R3 b_new", 32'(b_new), 32'(bn));
        chk("R6/R7 push count", 32'(pushes), (act == 1) ? 2 : 0);
        chk("R8 pop count", 32'(pops), (act == 2) ? 2 : 0);
        if (act == 1 && pushes == 2) begin
            chk("R6 push high first", 32'(pb[0]), 32'(pc[15:8]));
            chk("R6 push low second", 32'(pb[1]), 32'(pc[7:0]));
        end
        @(negedge clk);
        chk("R9 done one-cycle pulse", 32'(done), 0);
    endtask

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 0; op_valid = 0; opcode = 0; flags = 0; b_in = 0; pc_in = 0;
        operand = 0; hl_in = 0; stk_ack = 0; stk_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 ready", 32'(ready), 1);
        chk("R11 done", 32'(done), 0);
        chk("R11 redirect", 32'(redirect), 0);
        chk("R11 b_wr", 32'(b_wr), 0);
        chk("R11 push req", 32'(stk_push_req), 0);
        chk("R11 pop req", 32'(stk_pop_req), 0);

        // Sweep all opcodes over all S/Z/PV/C combinations (R1..R10)
        for (int op = 0; op < 256; op++) begin
            for (int fl = 0; fl < 16; fl++) begin
                logic [7:0] f;
                f = {fl[3], fl[2], op[3:1], fl[1], op[0], fl[0]};
                run_op(8'(op), f, 8'(op ^ (fl * 17)), 16'(16'h4000 + op * 3),
                       {8'(op ^ 8'hA5), 8'(fl * 16 + op % 16)}, 16'(16'h1234 ^ op),
                       (op + fl) % 3, 8'(op), 8'(~op ^ fl));
            end
        end

        // R3: loop counter boundary sweep, including 0 and 1
        for (int b = 0; b < 256; b++) begin
            run_op(8'h10, 8'h00, 8'(b), 16'h8000, {8'h00, 8'(b)}, 16'h0, 0, 8'h0, 8'h0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule